// File: doc/BRIEF.md
# Dual SRAM Buffer Serial Reader

This block is an SPI-slave read port for two independent 264-byte SRAM buffers held inside it. A host lowers chip select and clocks in one opcode byte, which picks one of the two buffers. The opcode is followed by a 24-bit address field and one dummy byte. After that, the block streams bytes from the chosen buffer for as long as chip select stays low. The address field carries the starting byte offset in its low nine bits. The stream runs through the buffer in order and returns to byte 0 after byte 263.

The SPI pins are brought into the system clock domain through a synchronizer chain, and all sequencing runs on the system clock. The serial output has a separate enable. The enable stays low through the command phase, for any opcode that is not recognised, and whenever chip select is high. An outer pad or bus can use this enable to tri-state the line. Both buffers are filled through a plain parallel write port, which is used for test setup.

Top module: `dual_buf_reader`

## Requirements
- R1: Opcodes 0x54 and 0xD4 read buffer 0, loaded with `ld_buf`=0. Opcodes 0x56 and 0xD6 read buffer 1, loaded with `ld_buf`=1.
- R2: A command frame is 8 opcode bits, then 24 address bits, then 8 dummy bits, all MSB first. The last 9 address bits received are the starting offset, and the first 15 address bits are ignored. Data starts on the SCK falling edge that follows the 40th rising edge.
- R3: MOSI is sampled on SCK rising edges. MISO changes only on SCK falling edges, MSB first, and holds its value while SCK is high.
- R4: Bytes are streamed at consecutive offsets. After offset 263 the stream continues at offset 0 of the same buffer, with no gap.
- R5: A starting offset of 264 to 511 is treated as offset 0.
- R6: `spi_miso_oe` is low while chip select is high and throughout the command phase. A rising edge on chip select ends the read, including in the middle of a byte, and the next frame starts afresh.
- R7: An opcode other than the four in R1 leaves `spi_miso_oe` low until chip select rises.
- R8: A parallel write (`ld_en`=1) stores `ld_data` at `ld_addr` in buffer `ld_buf`. The new value is seen the next time the stream fetches that byte, including during an active read.
- R9: During and directly after reset, `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| ld_en | input | 1 | Parallel buffer write strobe |
| ld_buf | input | 1 | Buffer chosen for the parallel write |
| ld_addr | input | 9 | Byte offset for the parallel write |
| ld_data | input | 8 | Byte written by the parallel write |

## Verification
The bench builds the block with its default 264-byte buffers and a two-stage synchronizer, and drives SCK at one eighth of the system clock. Because the buffer is that small, the bench can start a read at every legal offset and cycle through all four valid opcodes along the way. It can also stream one complete circuit of a buffer past the 263-to-0 wrap and back to its start byte. Out-of-range starts, mid-byte aborts, unknown opcodes and writes into a live stream are each run against byte values the bench computes from a formula.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  localparam int NUM_BUF   = 2;
  localparam int BUF_SEL_W = 1;
  localparam int BYTE_W    = 8;
  localparam int OFS_W     = 9;
  localparam int OPC_BITS  = 8;
  localparam int ADR_BITS  = 24;
  localparam int DUM_BITS  = 8;
  localparam int HDR_BITS  = OPC_BITS + ADR_BITS + DUM_BITS;
  localparam int HDR_CNT_W = $clog2(HDR_BITS + 1);

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_DUM,
    PH_DAT,
    PH_IGN
  } phase_e;

  typedef struct packed {
    logic hit;
    logic sel;
  } op_dec_t;

  // Low seven bits pick the command; bit 1 chooses the buffer.
  function automatic op_dec_t decode_op(input logic [OPC_BITS-1:0] op);
    op_dec_t r;
    r.hit = (op[6:0] == 7'h54) || (op[6:0] == 7'h56);
    r.sel = op[1];
    return r;
  endfunction

  function automatic logic [OFS_W-1:0] start_ofs(input logic [OFS_W-1:0] a,
                                                 input int depth);
    return (int'(a) < depth) ? a : '0;
  endfunction

  function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] a,
                                                input int depth);
    return (int'(a) == depth - 1) ? '0 : a + 1'b1;
  endfunction

endpackage

// File: rtl/dbr_pin_sync.sv
module dbr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_idle,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);

  logic [STAGES-1:0] cs_ff, sck_ff, mosi_ff;
  logic sck_prev;
  logic sck_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_ff    <= '1;
      sck_ff   <= '0;
      mosi_ff  <= '0;
      sck_prev <= 1'b0;
    end else begin
      cs_ff    <= {cs_ff[STAGES-2:0], cs_n};
      sck_ff   <= {sck_ff[STAGES-2:0], sck};
      mosi_ff  <= {mosi_ff[STAGES-2:0], mosi};
      sck_prev <= sck_now;
    end
  end

  assign sck_now  = sck_ff[STAGES-1];
  assign cs_idle  = cs_ff[STAGES-1];
  assign mosi_s   = mosi_ff[STAGES-1];
  assign sck_rise = sck_now & ~sck_prev;
  assign sck_fall = ~sck_now & sck_prev;

endmodule

// File: rtl/dbr_buf_bank.sv
module dbr_buf_bank
  import dbr_pkg::*;
#(
  parameter int BUF_BYTES = 264
) (
  input  logic                 clk,
  input  logic                 ld_en,
  input  logic [BUF_SEL_W-1:0] ld_buf,
  input  logic [OFS_W-1:0]     ld_addr,
  input  logic [BYTE_W-1:0]    ld_data,
  input  logic [BUF_SEL_W-1:0] rd_sel,
  input  logic [OFS_W-1:0]     rd_addr,
  output logic [BYTE_W-1:0]    rd_data
);

  logic [BYTE_W-1:0] bank_q [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic [BYTE_W-1:0] mem [BUF_BYTES];
    logic              wr_hit;

    assign wr_hit = ld_en && (ld_buf == BUF_SEL_W'(g)) && (int'(ld_addr) < BUF_BYTES);

    always_ff @(posedge clk) begin
      if (wr_hit) mem[ld_addr] <= ld_data;
    end

    assign bank_q[g] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_sel];

endmodule

// File: rtl/dbr_cmd_seq.sv
module dbr_cmd_seq
  import dbr_pkg::*;
#(
  parameter int BUF_BYTES = 264
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_idle,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 mosi_s,
  input  logic [BYTE_W-1:0]    rd_data,
  output logic [BUF_SEL_W-1:0] rd_sel,
  output logic [OFS_W-1:0]     rd_addr,
  output logic                 fetch_evt,
  output logic                 miso_q,
  output logic                 oe_q,
  output phase_e               phase
);

  localparam logic [HDR_CNT_W-1:0] LAST_OPC = HDR_CNT_W'(OPC_BITS - 1);
  localparam logic [HDR_CNT_W-1:0] LAST_ADR = HDR_CNT_W'(OPC_BITS + ADR_BITS - 1);
  localparam logic [HDR_CNT_W-1:0] LAST_DUM = HDR_CNT_W'(HDR_BITS - 1);

  logic [HDR_CNT_W-1:0] cnt;
  logic [ADR_BITS-1:0]  shin, nxt_shin;
  logic [BUF_SEL_W-1:0] sel_q;
  logic [OFS_W-1:0]     ofs_q;
  logic [BYTE_W-2:0]    sh_out;
  logic [2:0]           bit_left;
  logic                 in_hdr;
  op_dec_t              dec;

  assign nxt_shin  = {shin[ADR_BITS-2:0], mosi_s};
  assign dec       = decode_op(nxt_shin[OPC_BITS-1:0]);
  assign in_hdr    = (phase == PH_OPC) || (phase == PH_ADR) || (phase == PH_DUM);
  assign fetch_evt = !cs_idle && sck_fall && (phase == PH_DAT) && (bit_left == 3'd0);
  assign rd_sel    = sel_q;
  assign rd_addr   = ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      cnt      <= '0;
      shin     <= '0;
      sel_q    <= '0;
      ofs_q    <= '0;
      sh_out   <= '0;
      bit_left <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (cs_idle) begin
      phase    <= PH_OPC;
      cnt      <= '0;
      bit_left <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (sck_rise && in_hdr) begin
        shin <= nxt_shin;
        cnt  <= cnt + 1'b1;
        case (phase)
          PH_OPC: if (cnt == LAST_OPC) begin
            if (dec.hit) begin
              sel_q <= BUF_SEL_W'(dec.sel);
              phase <= PH_ADR;
            end else begin
              phase <= PH_IGN;
            end
          end
          PH_ADR: if (cnt == LAST_ADR) begin
            ofs_q <= start_ofs(nxt_shin[OFS_W-1:0], BUF_BYTES);
            phase <= PH_DUM;
          end
          PH_DUM: if (cnt == LAST_DUM) begin
            phase    <= PH_DAT;
            bit_left <= '0;
          end
          default: ;
        endcase
      end
      if (sck_fall && (phase == PH_DAT)) begin
        oe_q <= 1'b1;
        if (bit_left == 3'd0) begin
          miso_q   <= rd_data[BYTE_W-1];
          sh_out   <= rd_data[BYTE_W-2:0];
          bit_left <= 3'd7;
          ofs_q    <= next_ofs(ofs_q, BUF_BYTES);
        end else begin
          miso_q   <= sh_out[BYTE_W-2];
          sh_out   <= {sh_out[BYTE_W-3:0], 1'b0};
          bit_left <= bit_left - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dual_buf_reader.sv
module dual_buf_reader
  import dbr_pkg::*;
#(
  parameter int BUF_BYTES   = 264,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_cs_n,
  input  logic                 spi_sck,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 spi_miso_oe,
  input  logic                 ld_en,
  input  logic [BUF_SEL_W-1:0] ld_buf,
  input  logic [OFS_W-1:0]     ld_addr,
  input  logic [BYTE_W-1:0]    ld_data
);

  logic                 cs_idle, sck_rise, sck_fall, mosi_s;
  logic [BUF_SEL_W-1:0] rd_sel;
  logic [OFS_W-1:0]     rd_addr;
  logic [BYTE_W-1:0]    rd_data;
  logic                 fetch_evt;
  phase_e               phase;
  logic                 in_data, in_ignore;

  dbr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .cs_idle(cs_idle), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  dbr_buf_bank #(.BUF_BYTES(BUF_BYTES)) u_bank (
    .clk(clk), .ld_en(ld_en), .ld_buf(ld_buf), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  dbr_cmd_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .rd_data(rd_data), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .fetch_evt(fetch_evt), .miso_q(spi_miso),
    .oe_q(spi_miso_oe), .phase(phase)
  );

  assign in_data   = (phase == PH_DAT);
  assign in_ignore = (phase == PH_IGN);

endmodule

// File: rtl/dbr_chk.sv
module dbr_chk #(
  parameter int BUF_BYTES = 264
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_idle,
  input logic       sck_fall,
  input logic       fetch_evt,
  input logic [8:0] rd_addr,
  input logic       miso,
  input logic       miso_oe,
  input logic       in_data,
  input logic       in_ignore
);

  // R6
  oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !miso_oe);

  // R6
  oe_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> in_data);

  // R7
  oe_off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ignore |-> !miso_oe);

  // R3
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(miso));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_evt && (int'(rd_addr) == BUF_BYTES - 1)) |=> (rd_addr == 9'd0));

  // R5
  ofs_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_addr) < BUF_BYTES);

endmodule

bind dual_buf_reader dbr_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_fall(sck_fall),
  .fetch_evt(fetch_evt), .rd_addr(rd_addr), .miso(spi_miso),
  .miso_oe(spi_miso_oe), .in_data(in_data), .in_ignore(in_ignore)
);

// File: tb/tb_dual_buf_reader.sv
`timescale 1ns/1ps
module tb_dual_buf_reader;

  localparam int DEPTH = 264;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, oe;
  logic ld_en = 1'b0;
  logic ld_buf = 1'b0;
  logic [8:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dual_buf_reader #(.BUF_BYTES(DEPTH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .ld_en(ld_en), .ld_buf(ld_buf),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((i * 13) + (i / 256) * 128 + b * 90 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ld_write(input int b, input int a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_buf = b[0]; ld_addr = a[8:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic spi_bit(input logic b, output logic so, output logic oe_s, output logic stab);
    mosi = b;
    repeat (4) @(negedge clk);
    so = miso; oe_s = oe;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    stab = (miso == so);
    @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] adr, output logic oe_any);
    logic [39:0] frame;
    logic so, o, st;
    frame = {op, adr, 8'h5A};
    oe_any = 1'b0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 39; i >= 0; i--) begin
      spi_bit(frame[i], so, o, st);
      oe_any |= o;
    end
  endtask

  task automatic read_byte(output logic [7:0] v, output logic oe_all, output logic stab_all);
    logic so, o, st;
    v = '0; oe_all = 1'b1; stab_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      spi_bit(1'b0, so, o, st);
      v = {v[6:0], so};
      oe_all &= o;
      stab_all &= st;
    end
  endtask

  task automatic end_cs();
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic oe_any, oe_all, st;
    logic [7:0] v;
    logic [7:0] ops [4];
    ops[0] = 8'h54; ops[1] = 8'hD4; ops[2] = 8'h56; ops[3] = 8'hD6;

    repeat (5) @(negedge clk);
    chk(oe == 1'b0, "R9 oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0, "R9 oe after reset", int'(oe), 0);

    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) ld_write(b, i, pat(b, i));

    // R1 R2 R3: every legal start offset, all four opcodes, junk upper address bits
    for (int a = 0; a < DEPTH; a++) begin
      int b;
      b = (a % 4) / 2;
      send_cmd(ops[a % 4], {15'(a * 977 + 3), 9'(a)}, oe_any);
      chk(oe_any == 1'b0, "R6 oe low in command", int'(oe_any), 0);
      read_byte(v, oe_all, st);
      chk(v == pat(b, a), "R1 R2 first byte", int'(v), int'(pat(b, a)));
      chk(oe_all && st, "R3 oe and hold on high sck", int'({oe_all, st}), 3);
      end_cs();
    end

    // R4: wrap near the end
    send_cmd(8'h56, 24'd262, oe_any);
    for (int k = 0; k < 4; k++) begin
      read_byte(v, oe_all, st);
      chk(v == pat(1, (262 + k) % DEPTH), "R4 wrap sequence", int'(v), int'(pat(1, (262 + k) % DEPTH)));
    end
    end_cs();

    // R4: one full circuit plus one byte
    send_cmd(8'hD4, 24'd5, oe_any);
    for (int k = 0; k <= DEPTH; k++) begin
      read_byte(v, oe_all, st);
      if (k % 33 == 0 || k >= DEPTH - 2)
        chk(v == pat(0, (5 + k) % DEPTH), "R4 full circuit", int'(v), int'(pat(0, (5 + k) % DEPTH)));
    end
    end_cs();

    // R5: out-of-range starts
    foreach (ops[j]) begin
      int a, b;
      a = (j == 0) ? 264 : (j == 1) ? 300 : (j == 2) ? 511 : 400;
      b = j / 2;
      send_cmd(ops[j], {15'h7FFF, 9'(a)}, oe_any);
      read_byte(v, oe_all, st);
      chk(v == pat(b, 0), "R5 start clamp byte0", int'(v), int'(pat(b, 0)));
      read_byte(v, oe_all, st);
      chk(v == pat(b, 1), "R5 start clamp byte1", int'(v), int'(pat(b, 1)));
      end_cs();
    end

    // R6: abort mid-byte, then a fresh frame
    send_cmd(8'h56, 24'd100, oe_any);
    begin
      logic so, o, s2;
      for (int i = 0; i < 3; i++) spi_bit(1'b0, so, o, s2);
    end
    end_cs();
    chk(oe == 1'b0, "R6 oe after cs rise", int'(oe), 0);
    send_cmd(8'hD6, 24'd100, oe_any);
    read_byte(v, oe_all, st);
    chk(v == pat(1, 100), "R6 fresh frame after abort", int'(v), int'(pat(1, 100)));
    end_cs();

    // R7: unknown opcodes keep the output disabled
    begin
      logic [7:0] bad [4];
      bad[0] = 8'h55; bad[1] = 8'h52; bad[2] = 8'h00; bad[3] = 8'hD7;
      foreach (bad[j]) begin
        logic any_on;
        send_cmd(bad[j], 24'd7, oe_any);
        any_on = oe_any;
        for (int k = 0; k < 2; k++) begin
          read_byte(v, oe_all, st);
          any_on |= oe_all;
        end
        chk(!any_on && oe == 1'b0, "R7 unknown opcode silent", int'(any_on), 0);
        end_cs();
      end
    end

    // R8: write into a live stream
    send_cmd(8'h54, 24'd10, oe_any);
    ld_write(0, 11, 8'hEE);
    read_byte(v, oe_all, st);
    chk(v == pat(0, 10), "R8 byte before write", int'(v), int'(pat(0, 10)));
    read_byte(v, oe_all, st);
    chk(v == 8'hEE, "R8 written byte seen", int'(v), 32'hEE);
    end_cs();
    ld_write(1, 263, 8'h3C);
    send_cmd(8'hD6, 24'd263, oe_any);
    read_byte(v, oe_all, st);
    chk(v == 8'h3C, "R8 write buffer1 last byte", int'(v), 32'h3C);
    read_byte(v, oe_all, st);
    chk(v == pat(1, 0), "R8 R4 wrap after write", int'(v), int'(pat(1, 0)));
    end_cs();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule